// File: doc/BRIEF.md
# Bus Glue Decoder with Programmed-I/O Port

This block is the address-decode glue for a small 8-bit processor system with a 16-bit address bus. Each bus cycle, it looks at the top address bits, qualified by the processor's operation-request strobe, and drives one active-low select. The selects go to a 16 kByte static RAM, a 1 kByte ROM and a serial controller with eight registers. It also passes each device the low address lines that device uses.

The top of the 0x6000–0x7FFF window holds a programmed-I/O port. A processor write there loads an 8-bit register whose outputs drive indicator lamps. A processor read there places the state of eight switches on the data bus. The switch path is modelled as a read-data value plus an output-enable, so the surrounding chip can drive a tri-state pad or a bus multiplexer from it. The selects and the read path are combinational within the cycle. The lamp register is the only storage in the block.

Memory map, decoded from address bits 15..12: RAM at 0x0000–0x3FFF, ROM at 0x4000–0x5FFF (mirrored every 1 kByte), serial controller at 0x6000–0x6FFF (mirrored every 8 bytes), I/O port at 0x7000–0x7FFF (every address in the window is the same port), and nothing at 0x8000–0xFFFF.

Top module: `bus_glue`

## Requirements
- R1: `ram_sel_n` is low exactly when `op_req` is high and address bits 15..14 are 00; `ram_addr` always equals address bits 13..0.
- R2: `rom_sel_n` is low exactly when `op_req` is high and address bits 15..13 are 010; `rom_addr` always equals address bits 9..0.
- R3: `uart_sel_n` is low exactly when `op_req` is high and address bits 15..12 are 0110; `uart_addr` always equals address bits 2..0.
- R4: When `op_req` is low, all three selects are high and `rd_oe` is low, whatever the address and direction.
- R5: Addresses with bit 15 set select no device. At no time is more than one of {RAM select, ROM select, serial select, `rd_oe`} active.
- R6: On a rising clock edge with `op_req` high, `rd_nwr` low (write) and address bits 15..12 equal to 0111, `led` takes the value of `wr_data` and shows it from that edge onward. Address bits 11..0 have no effect.
- R7: `led` keeps its value on every other edge. This includes reads of the port, writes to other regions, and writes to the port with `op_req` low.
- R8: While `rst_n` is low, `led` is 0.
- R9: `rd_oe` is high and `rd_data` equals `sw` exactly when `op_req` is high, `rd_nwr` is high (read) and address bits 15..12 are 0111. Otherwise `rd_oe` is low and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the lamp register |
| addr | input | 16 | Processor address bus |
| op_req | input | 1 | Operation-request strobe, high during a bus cycle |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| wr_data | input | 8 | Processor write data |
| sw | input | 8 | Switch inputs |
| ram_sel_n | output | 1 | Active-low RAM select |
| rom_sel_n | output | 1 | Active-low ROM select |
| uart_sel_n | output | 1 | Active-low serial-controller select |
| ram_addr | output | 14 | RAM address lines |
| rom_addr | output | 10 | ROM address lines |
| uart_addr | output | 3 | Serial-controller register index |
| led | output | 8 | Lamp register outputs |
| rd_data | output | 8 | Switch data toward the bus |
| rd_oe | output | 1 | Output enable for `rd_data` |

## Verification
The hardest case to reach is a near-miss of the lamp register. In these cycles the address is in the port window but the strobe or the direction is wrong, or the direction is a write but the address lies just outside the window (0x6FFF, 0x8000). Any wrong decode would then corrupt `led` without a visible select. The stimulus first loads a distinctive pattern into the register. It then issues these near-miss cycles back to back, with `wr_data` set to a different pattern, and compares `led` after every edge. It also writes at mirror addresses such as 0x7ABC to show that the low bits are ignored.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;

    // Decoded device region of the current bus cycle
    typedef enum logic [2:0] {
        RGN_NONE = 3'd0,
        RGN_RAM  = 3'd1,
        RGN_ROM  = 3'd2,
        RGN_UART = 3'd3,
        RGN_PIO  = 3'd4
    } region_e;

    // Number of upper address bits examined by the decoder
    localparam int DEC_BITS = 4;

endpackage

// File: rtl/bus_glue_decode.sv
module bus_glue_decode
    import bus_glue_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              op_req_i,
    output region_e           region_o
);

    localparam int HI_LSB = ADDR_W - DEC_BITS;

    logic [DEC_BITS-1:0] hi;

    always_comb begin
        hi       = addr_i[ADDR_W-1:HI_LSB];
        region_o = RGN_NONE;
        if (op_req_i) begin
            casez (hi)
                4'b00??: region_o = RGN_RAM;
                4'b010?: region_o = RGN_ROM;
                4'b0110: region_o = RGN_UART;
                4'b0111: region_o = RGN_PIO;
                default: region_o = RGN_NONE;
            endcase
        end
    end

endmodule

// File: rtl/bus_glue_led.sv
module bus_glue_led #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] led_o
);

    typedef struct packed {
        logic [DATA_W-1:0] led;
    } led_state_t;

    led_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_stb_i) begin
            state_d.led = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign led_o = state_q.led;

    AST_LED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_i |=> led_o == $past(wr_data_i)); // R6

    AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> $stable(led_o)); // R7

endmodule

// File: rtl/bus_glue_rdpath.sv
module bus_glue_rdpath #(
    parameter int DATA_W = 8
) (
    input  logic              rd_stb_i,
    input  logic [DATA_W-1:0] sw_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_oe_o
);

    always_comb begin
        rd_oe_o   = rd_stb_i;
        rd_data_o = rd_stb_i ? sw_i : '0;
    end

endmodule

// File: rtl/bus_glue.sv
module bus_glue
    import bus_glue_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int RAM_AW  = 14,
    parameter int ROM_AW  = 10,
    parameter int UART_AW = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               op_req,
    input  logic               rd_nwr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [DATA_W-1:0]  sw,
    output logic               ram_sel_n,
    output logic               rom_sel_n,
    output logic               uart_sel_n,
    output logic [RAM_AW-1:0]  ram_addr,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic [UART_AW-1:0] uart_addr,
    output logic [DATA_W-1:0]  led,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_oe
);

    region_e region;
    logic    pio_wr_stb;
    logic    pio_rd_stb;

    bus_glue_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr_i   (addr),
        .op_req_i (op_req),
        .region_o (region)
    );

    always_comb begin
        ram_sel_n  = (region != RGN_RAM);
        rom_sel_n  = (region != RGN_ROM);
        uart_sel_n = (region != RGN_UART);
        pio_wr_stb = (region == RGN_PIO) && !rd_nwr;
        pio_rd_stb = (region == RGN_PIO) &&  rd_nwr;
        ram_addr   = addr[RAM_AW-1:0];
        rom_addr   = addr[ROM_AW-1:0];
        uart_addr  = addr[UART_AW-1:0];
    end

    bus_glue_led #(.DATA_W(DATA_W)) i_led (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (pio_wr_stb),
        .wr_data_i (wr_data),
        .led_o     (led)
    );

    bus_glue_rdpath #(.DATA_W(DATA_W)) i_rdpath (
        .rd_stb_i  (pio_rd_stb),
        .sw_i      (sw),
        .rd_data_o (rd_data),
        .rd_oe_o   (rd_oe)
    );

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~ram_sel_n, ~rom_sel_n, ~uart_sel_n, rd_oe}) <= 1); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_req |-> (ram_sel_n && rom_sel_n && uart_sel_n && !rd_oe)); // R4

    AST_RAM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_n |-> (addr[ADDR_W-1 -: 2] == 2'b00)); // R1

    AST_RD_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> (rd_nwr && rd_data == sw)); // R9

    AST_HIGH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        addr[ADDR_W-1] |-> (ram_sel_n && rom_sel_n && uart_sel_n && !rd_oe)); // R5

endmodule

// File: tb/test_bus_glue.sv
module test_bus_glue;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        op_req = 1'b0;
    logic        rd_nwr = 1'b1;
    logic [7:0]  wr_data = '0;
    logic [7:0]  sw = '0;
    logic        ram_sel_n, rom_sel_n, uart_sel_n;
    logic [13:0] ram_addr;
    logic [9:0]  rom_addr;
    logic [2:0]  uart_addr;
    logic [7:0]  led, rd_data;
    logic        rd_oe;

    int checks = 0;
    int failures = 0;
    logic [7:0] led_model = '0;

    typedef struct {
        logic [15:0] a;
        logic        ram_n, rom_n, uart_n, oe;
        logic [7:0]  rdat;
        logic [7:0]  ledv;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    bus_glue i_bus_glue (
        .clk(clk), .rst_n(rst_n), .addr(addr), .op_req(op_req), .rd_nwr(rd_nwr),
        .wr_data(wr_data), .sw(sw), .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n),
        .uart_sel_n(uart_sel_n), .ram_addr(ram_addr), .rom_addr(rom_addr),
        .uart_addr(uart_addr), .led(led), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: set inputs at falling edge, push expected item, update lamp model
    task automatic drive(input logic [15:0] a, input logic op, input logic rd,
                         input logic [7:0] wd, input logic [7:0] s, input string req);
        item_t it;
        logic pio;
        @(negedge clk);
        addr = a; op_req = op; rd_nwr = rd; wr_data = wd; sw = s;
        pio       = op && (a >= 16'h7000) && (a <= 16'h7FFF);
        it.a      = a;
        it.ram_n  = !(op && a < 16'h4000);
        it.rom_n  = !(op && a >= 16'h4000 && a < 16'h6000);
        it.uart_n = !(op && a >= 16'h6000 && a < 16'h7000);
        it.oe     = pio && rd;
        it.rdat   = (pio && rd) ? s : 8'h00;
        it.ledv   = led_model;
        it.req    = req;
        sb_q.push_back(it);
        if (pio && !rd) led_model = wd;
    endtask

    // Monitor: compare a little after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.req, "ram_sel_n",  int'(ram_sel_n),  int'(it.ram_n));
                check(it.req, "rom_sel_n",  int'(rom_sel_n),  int'(it.rom_n));
                check(it.req, "uart_sel_n", int'(uart_sel_n), int'(it.uart_n));
                check(it.req, "rd_oe",      int'(rd_oe),      int'(it.oe));
                check(it.req, "rd_data",    int'(rd_data),    int'(it.rdat));
                check(it.req, "led",        int'(led),        int'(it.ledv));
                check(it.req, "ram_addr",   int'(ram_addr),   int'(it.a[13:0]));
                check(it.req, "rom_addr",   int'(rom_addr),   int'(it.a[9:0]));
                check(it.req, "uart_addr",  int'(uart_addr),  int'(it.a[2:0]));
            end
        end
    end

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R8: reset value
        repeat (3) @(negedge clk);
        check("R8", "led in reset", int'(led), 0);
        rst_n = 1'b1;

        // R1 RAM, including boundaries
        drive(16'h0000, 1, 1, 8'h00, 8'h00, "R1");
        drive(16'h3FFF, 1, 0, 8'h11, 8'h00, "R1");
        drive(16'h1A5C, 1, 1, 8'h00, 8'h00, "R1");
        // R2 ROM and mirrors
        drive(16'h4000, 1, 1, 8'h00, 8'h00, "R2");
        drive(16'h5FFF, 1, 1, 8'h00, 8'h00, "R2");
        drive(16'h47B3, 1, 0, 8'h22, 8'h00, "R2");
        // R3 serial controller
        drive(16'h6000, 1, 1, 8'h00, 8'h00, "R3");
        drive(16'h6FFD, 1, 0, 8'h33, 8'h00, "R3");
        // R4 strobe low over all regions
        drive(16'h0123, 0, 1, 8'h00, 8'hFF, "R4");
        drive(16'h4123, 0, 0, 8'h44, 8'hFF, "R4");
        drive(16'h6005, 0, 1, 8'h00, 8'hFF, "R4");
        drive(16'h7000, 0, 1, 8'h00, 8'hFF, "R4");
        // R5 upper half empty
        drive(16'h8000, 1, 1, 8'h00, 8'hAA, "R5");
        drive(16'hF000, 1, 0, 8'h55, 8'hAA, "R5");
        drive(16'hFFFF, 1, 1, 8'h00, 8'hAA, "R5");
        // R6 port write, then mirror write
        drive(16'h7000, 1, 0, 8'hA5, 8'h00, "R6");
        drive(16'h7ABC, 1, 0, 8'h3C, 8'h00, "R6");
        drive(16'h7FFF, 1, 0, 8'hC3, 8'h00, "R6");
        // R7 near misses must leave C3
        drive(16'h7000, 1, 1, 8'h00, 8'h5A, "R7");
        drive(16'h7000, 0, 0, 8'h00, 8'h00, "R7");
        drive(16'h6FFF, 1, 0, 8'h00, 8'h00, "R7");
        drive(16'h8000, 1, 0, 8'h00, 8'h00, "R7");
        drive(16'hF7FF, 1, 0, 8'h00, 8'h00, "R7");
        drive(16'h1000, 1, 0, 8'h00, 8'h00, "R7");
        // R9 switch reads with several patterns
        drive(16'h7000, 1, 1, 8'h00, 8'h96, "R9");
        drive(16'h7123, 1, 1, 8'h00, 8'h01, "R9");
        drive(16'h7FFF, 1, 1, 8'h00, 8'hFF, "R9");
        drive(16'h7000, 1, 0, 8'h7E, 8'hFF, "R9");
        drive(16'h7000, 1, 1, 8'h00, 8'h00, "R9");
        drive(16'h0000, 0, 1, 8'h00, 8'h00, "R6");
        drive(16'h0000, 0, 1, 8'h00, 8'h00, "R7");

        // R8: reset clears a loaded register
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R8", "led after reset", int'(led), 0);
        led_model = '0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(16'h2000, 1, 1, 8'h00, 8'h00, "R8");
        repeat (2) @(negedge clk);
        #4;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule